// File: doc/BRIEF.md
# Line Loss-of-Signal Declare/Clear Detector

This block tracks whether a received line is alive. It sees the line one pulse interval at a time. Each interval arrives as a one-cycle strobe, together with two flags from the analog front end. One flag says a pulse (mark) arrived with an amplitude above the clear threshold. The other says the level sat below the declare threshold. From these the block keeps a loss-of-signal status bit, and that bit is set and cleared by different rules.

The status bit is set after a mode-dependent run of empty, low-level intervals. It is cleared only after a fixed-length observation window that opens on a received pulse. That window must meet a minimum mark count and must also stay under a consecutive-zero limit. A one-cycle interrupt pulse marks each declare unless it is masked. Two alarm enables make the block replace the receive data, the transmit data, or both with all ones while the status is set, and flag that the master clock times that data.

Top module: `los_monitor`

## Requirements
- R1: While the status is low, each strobe with mark_in=0 and low_lvl=1 counts one empty interval. The status rises on the clock edge that takes in the N-th consecutive empty interval. N is 175 for mode_e1=0 with crit_sel=0, 1544 for mode_e1=0 with crit_sel=1, 32 for mode_e1=1 with crit_sel=0, and 2048 for mode_e1=1 with crit_sel=1.
- R2: A strobe with mark_in=1, or with low_lvl=0, sets the empty-interval count back to zero. The count saturates and never wraps.
- R3: While the status is high, a strobe with mark_in=1 and low_lvl=0 opens an observation window, and that strobe is interval 1. The window is M intervals long: M is 128 for mode_e1=0 and 32 for mode_e1=1. The status can fall only on the edge that takes in interval M.
- R4: To clear, a window must contain at least M/8 marks, which is 16 for mode_e1=0 and 4 for mode_e1=1.
- R5: To clear, no run of consecutive zero intervals inside the window may reach 100 for mode_e1=0, or 16 for mode_e1=1.
- R6: A strobe with low_lvl=1 inside an open window abandons that window at once.
- R7: A window that fails R4 or R5 still runs its full M intervals and is then dropped. The next window opens at the next mark.
- R8: irq is high for exactly one cycle, in the same cycle the status rises, when irq_mask=0. It stays low when irq_mask=1.
- R9: While the status is high and rx_alarm_en=1, rx_bit_out is 1 and rx_use_mclk is 1. Otherwise rx_bit_out follows rx_bit_in and rx_use_mclk is 0.
- R10: While the status is high and tx_alarm_en=1, tx_bit_out is 1 and tx_use_mclk is 1. Otherwise tx_bit_out follows tx_bit_in and tx_use_mclk is 0.
- R11: A change of mode_e1 or crit_sel restarts the empty-interval count and any open window. The status bit keeps its value.
- R12: After reset the status, irq, rx_use_mclk and tx_use_mclk are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One received pulse interval |
| mark_in | input | 1 | Pulse above the clear threshold in this interval |
| low_lvl | input | 1 | Level below the declare threshold in this interval |
| mode_e1 | input | 1 | 1 = E1 rates, 0 = T1 rates |
| crit_sel | input | 1 | Selects the long or short declare count |
| irq_mask | input | 1 | 1 suppresses the declare interrupt |
| rx_alarm_en | input | 1 | All-ones substitution on receive data while in loss |
| tx_alarm_en | input | 1 | All-ones substitution on transmit data while in loss |
| rx_bit_in | input | 1 | Recovered receive data |
| tx_bit_in | input | 1 | Data headed for the line |
| los | output | 1 | Loss-of-signal status |
| irq | output | 1 | One-cycle declare interrupt |
| rx_bit_out | output | 1 | Receive data after substitution |
| rx_use_mclk | output | 1 | Receive data is timed by the master clock |
| tx_bit_out | output | 1 | Transmit data after substitution |
| tx_use_mclk | output | 1 | Transmit data is timed by the master clock |

## Verification
The embedded properties assume that mode_e1 and crit_sel change only between strobes. They also assume that mark_in and low_lvl are meaningful only while bit_stb is high. The bench changes the configuration only with bit_stb low and then waits two idle cycles before it strobes again. It never asserts mark_in and low_lvl in the same interval. Each case starts from a fresh reset and a known status, so every declare and clear edge can be predicted exactly from the interval counts.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int DCNT_W = 12;
  localparam int WCNT_W = 8;

  // empty intervals required to declare
  function automatic int decl_len(input logic e1, input logic crit);
    if (e1) return crit ? 2048 : 32;
    else    return crit ? 1544 : 175;
  endfunction

  // observation window length
  function automatic int win_len(input logic e1);
    return e1 ? 32 : 128;
  endfunction

  // minimum marks inside a window (one in eight)
  function automatic int min_marks(input logic e1);
    return win_len(e1) / 8;
  endfunction

  // zero run length that spoils a window
  function automatic int zero_lim(input logic e1);
    return e1 ? 16 : 100;
  endfunction
endpackage

// File: rtl/los_decl.sv
module los_decl #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          los,
  input  logic          bit_stb,
  input  logic          mark_in,
  input  logic          low_lvl,
  input  logic [CW-1:0] limit,
  output logic          decl_evt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] dcnt;
  logic [CW:0]   dcnt_inc;
  logic          empty_iv;

  assign empty_iv = bit_stb & ~mark_in & low_lvl;
  assign dcnt_inc = {1'b0, dcnt} + 1'b1;
  assign decl_evt = ~los & empty_iv & (dcnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || restart || los) begin
      dcnt <= '0;
    end else if (bit_stb) begin
      if (!empty_iv)         dcnt <= '0;
      else if (decl_evt)     dcnt <= '0;
      else if (dcnt != CMAX) dcnt <= dcnt_inc[CW-1:0];
    end
  end

  // R1
  cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !los |-> (dcnt < limit));

  // R2
  mark_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && mark_in) |=> (dcnt == '0));
endmodule

// File: rtl/los_clrwin.sv
module los_clrwin #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          los,
  input  logic          bit_stb,
  input  logic          mark_in,
  input  logic          low_lvl,
  input  logic [WW-1:0] win_m,
  input  logic [WW-1:0] min_m,
  input  logic [WW-1:0] zlim,
  output logic          clr_evt
);
  localparam logic [WW-1:0] WMAX = '1;

  logic          active;
  logic [WW-1:0] wcnt, mcnt, zrun;
  logic          zfail;
  logic [WW-1:0] wcnt_n, mcnt_n, zrun_n;
  logic          zfail_n, win_last, win_open;

  always_comb begin
    wcnt_n  = wcnt + 1'b1;
    mcnt_n  = mcnt + {{(WW-1){1'b0}}, mark_in};
    if (mark_in)           zrun_n = '0;
    else if (zrun != WMAX) zrun_n = zrun + 1'b1;
    else                   zrun_n = zrun;
    zfail_n  = zfail | (zrun_n >= zlim);
    win_open = los & ~active & bit_stb & mark_in & ~low_lvl;
    win_last = active & bit_stb & ~low_lvl & (wcnt_n == win_m);
    clr_evt  = win_last & (mcnt_n >= min_m) & ~zfail_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !los) begin
      active <= 1'b0;
      wcnt   <= '0;
      mcnt   <= '0;
      zrun   <= '0;
      zfail  <= 1'b0;
    end else if (bit_stb) begin
      if (win_open) begin
        active <= 1'b1;
        wcnt   <= {{(WW-1){1'b0}}, 1'b1};
        mcnt   <= {{(WW-1){1'b0}}, 1'b1};
        zrun   <= '0;
        zfail  <= 1'b0;
      end else if (active) begin
        if (low_lvl || win_last) begin
          active <= 1'b0;
        end else begin
          wcnt  <= wcnt_n;
          mcnt  <= mcnt_n;
          zrun  <= zrun_n;
          zfail <= zfail_n;
        end
      end
    end
  end

  // R3
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (wcnt < win_m));

  // R4
  marks_le_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (mcnt <= wcnt));

  // R6
  low_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_stb && low_lvl) |=> !active);
endmodule

// File: rtl/los_alarm.sv
module los_alarm (
  input  logic los,
  input  logic alarm_en,
  input  logic bit_in,
  output logic bit_out,
  output logic use_mclk
);
  logic subst;
  assign subst    = los & alarm_en;
  assign use_mclk = subst;
  assign bit_out  = subst | bit_in;

  // R9 R10
  always_comb begin
    if (!los) subst_idle_chk: assert (bit_out == bit_in);
  end
endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int DW = DCNT_W,
  parameter int WW = WCNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic mark_in,
  input  logic low_lvl,
  input  logic mode_e1,
  input  logic crit_sel,
  input  logic irq_mask,
  input  logic rx_alarm_en,
  input  logic tx_alarm_en,
  input  logic rx_bit_in,
  input  logic tx_bit_in,
  output logic los,
  output logic irq,
  output logic rx_bit_out,
  output logic rx_use_mclk,
  output logic tx_bit_out,
  output logic tx_use_mclk
);
  logic [1:0]    cfg_q;
  logic          restart;
  logic          decl_evt, clr_evt;
  logic [DW-1:0] n_lim;
  logic [WW-1:0] m_len, m_min, z_lim;

  assign restart = ({mode_e1, crit_sel} != cfg_q);
  assign n_lim   = DW'(decl_len(cfg_q[1], cfg_q[0]));
  assign m_len   = WW'(win_len(cfg_q[1]));
  assign m_min   = WW'(min_marks(cfg_q[1]));
  assign z_lim   = WW'(zero_lim(cfg_q[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= {mode_e1, crit_sel};
      los   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      cfg_q <= {mode_e1, crit_sel};
      irq   <= decl_evt & ~irq_mask;
      if (decl_evt)     los <= 1'b1;
      else if (clr_evt) los <= 1'b0;
    end
  end

  los_decl #(.CW(DW)) u_decl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .los(los),
    .bit_stb(bit_stb), .mark_in(mark_in), .low_lvl(low_lvl),
    .limit(n_lim), .decl_evt(decl_evt)
  );

  los_clrwin #(.WW(WW)) u_clr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .los(los),
    .bit_stb(bit_stb), .mark_in(mark_in), .low_lvl(low_lvl),
    .win_m(m_len), .min_m(m_min), .zlim(z_lim), .clr_evt(clr_evt)
  );

  los_alarm u_rx (
    .los(los), .alarm_en(rx_alarm_en), .bit_in(rx_bit_in),
    .bit_out(rx_bit_out), .use_mclk(rx_use_mclk)
  );

  los_alarm u_tx (
    .los(los), .alarm_en(tx_alarm_en), .bit_in(tx_bit_in),
    .bit_out(tx_bit_out), .use_mclk(tx_use_mclk)
  );

  // R1
  rise_on_decl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(decl_evt));

  // R3
  fall_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(clr_evt));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($rose(los) && !$past(irq_mask)));

  // R11
  cfg_keeps_los_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !decl_evt && !clr_evt) |=> $stable(los));
endmodule

// File: tb/tb_los_monitor.sv
module tb_los_monitor;
  logic clk = 1'b0;
  logic rst_n, bit_stb, mark_in, low_lvl, mode_e1, crit_sel, irq_mask;
  logic rx_alarm_en, tx_alarm_en, rx_bit_in, tx_bit_in;
  logic los, irq, rx_bit_out, rx_use_mclk, tx_bit_out, tx_use_mclk;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  los_monitor dut (.*);

  // columns: mode_e1, crit_sel, expected declare count
  localparam int VEC [4][3] = '{'{0, 0, 175}, '{0, 1, 1544}, '{1, 0, 32}, '{1, 1, 2048}};

  task automatic chk(input string r, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", r, a, e);
    end
  endtask

  task automatic tick(input logic m, input logic l);
    @(negedge clk); bit_stb = 1'b1; mark_in = m; low_lvl = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_stb = 1'b0; mark_in = 1'b0; low_lvl = 1'b0;
    end
  endtask

  task automatic do_reset(input logic e1, input logic cr);
    @(negedge clk);
    rst_n = 1'b0; bit_stb = 0; mark_in = 0; low_lvl = 0;
    mode_e1 = e1; crit_sel = cr;
    idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic empties(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1);
  endtask

  task automatic fresh_los(input logic e1);
    do_reset(e1, 1'b0);
    empties(e1 ? 32 : 175);
    idle(1);
  endtask

  task automatic send_win(input int len, input logic [127:0] pat);
    for (int i = 0; i < len; i++) tick(pat[i], 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] p;
    rst_n = 0; bit_stb = 0; mark_in = 0; low_lvl = 0; mode_e1 = 0; crit_sel = 0;
    irq_mask = 0; rx_alarm_en = 0; tx_alarm_en = 0; rx_bit_in = 0; tx_bit_in = 0;

    // R12 reset state
    do_reset(1'b0, 1'b0);
    chk("R12 los", los, 1'b0);
    chk("R12 irq", irq, 1'b0);
    chk("R12 rx_use_mclk", rx_use_mclk, 1'b0);
    chk("R12 tx_use_mclk", tx_use_mclk, 1'b0);

    // R1 R8: all four declare counts, exact edge
    for (int v = 0; v < 4; v++) begin
      do_reset(VEC[v][0][0], VEC[v][1][0]);
      empties(VEC[v][2] - 1); idle(1);
      chk("R1 before N", los, 1'b0);
      tick(1'b0, 1'b1); idle(1);
      chk("R1 at N", los, 1'b1);
      chk("R8 irq at declare", irq, 1'b1);
      idle(1);
      chk("R8 irq one cycle", irq, 1'b0);
    end

    // R8 masked
    irq_mask = 1'b1;
    do_reset(1'b1, 1'b0); empties(32); idle(1);
    chk("R8 masked los", los, 1'b1);
    chk("R8 masked irq", irq, 1'b0);
    irq_mask = 1'b0;

    // R2 mark resets count
    do_reset(1'b1, 1'b0);
    empties(31); tick(1'b1, 1'b0); empties(31); idle(1);
    chk("R2 mark restart", los, 1'b0);
    tick(1'b0, 1'b1); idle(1);
    chk("R2 after mark full run", los, 1'b1);

    // R2 level above threshold resets count
    do_reset(1'b1, 1'b0);
    empties(31); tick(1'b0, 1'b0); empties(31); idle(1);
    chk("R2 level restart", los, 1'b0);

    // R11 configuration change restarts the count
    do_reset(1'b1, 1'b0);
    empties(20); idle(1);
    crit_sel = 1'b1; idle(2); crit_sel = 1'b0; idle(2);
    empties(31); idle(1);
    chk("R11 restarted", los, 1'b0);
    tick(1'b0, 1'b1); idle(1);
    chk("R11 declare after restart", los, 1'b1);

    // R3 R4 R5 E1 boundary pass: marks 0,1,2,18, longest zero run 15, 4 marks
    fresh_los(1'b1);
    send_win(3, '0);
    p = '0; p[0] = 1; p[1] = 1; p[2] = 1; p[18] = 1;
    send_win(31, p); idle(1);
    chk("R3 not before M", los, 1'b1);
    tick(1'b0, 1'b0); idle(1);
    chk("R3 clear at M", los, 1'b0);

    // R9 R10 not in loss: pass through
    rx_alarm_en = 1; tx_alarm_en = 1; rx_bit_in = 0; tx_bit_in = 0; idle(1);
    chk("R9 idle pass", rx_bit_out, 1'b0);
    chk("R10 idle pass", tx_bit_out, 1'b0);

    // R4 density fail then R7 next window clears
    fresh_los(1'b1);
    chk("R9 forced", rx_bit_out, 1'b1);
    chk("R9 mclk", rx_use_mclk, 1'b1);
    chk("R10 forced", tx_bit_out, 1'b1);
    chk("R10 mclk", tx_use_mclk, 1'b1);
    rx_alarm_en = 0; tx_alarm_en = 0; idle(1);
    chk("R9 disabled", rx_bit_out, 1'b0);
    chk("R10 disabled", tx_use_mclk, 1'b0);
    p = '0; p[0] = 1; p[11] = 1; p[23] = 1;
    send_win(32, p); idle(1);
    chk("R4 density fail", los, 1'b1);
    p = '0; for (int i = 0; i < 32; i += 8) p[i] = 1;
    send_win(32, p); idle(1);
    chk("R7 next window", los, 1'b0);

    // R5 zero run of 16 fails in E1
    fresh_los(1'b1);
    p = '0; p[0] = 1; p[1] = 1; p[2] = 1; p[19] = 1;
    send_win(32, p); idle(1);
    chk("R5 E1 zero fail", los, 1'b1);

    // R6 low level aborts an open window
    fresh_los(1'b1);
    tick(1'b1, 1'b0);
    for (int i = 1; i < 11; i++) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    for (int i = 12; i < 32; i++) tick((i % 5) == 2, 1'b0);
    idle(1);
    chk("R6 aborted", los, 1'b1);

    // R3 R4 T1 window: 16 marks, runs of 7
    fresh_los(1'b0);
    p = '0; for (int i = 0; i < 128; i += 8) p[i] = 1;
    send_win(127, p); idle(1);
    chk("R3 T1 not before M", los, 1'b1);
    tick(1'b0, 1'b0); idle(1);
    chk("R4 T1 clear", los, 1'b0);

    // R5 T1 zero run of 100 fails
    fresh_los(1'b0);
    p = '0; for (int i = 0; i < 15; i++) p[i] = 1; p[115] = 1;
    send_win(128, p); idle(1);
    chk("R5 T1 zero fail", los, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule